// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits between a host's parallel write bus and the control logic of a byte-wide flash array. It watches every accepted write and recognises the multi-write unlock sequences that guard destructive operations. When a complete sequence has arrived, it raises one single-cycle request: program a byte, erase a sector, erase the whole chip, enable the boot-sector write lock, or enter or leave identification mode. The address and data of the final write travel with the request.

The block keeps track of whether identification mode is active. While that mode is on, reads return fixed identification bytes and the boot-lock state. Otherwise reads pass straight through from the array and status path. The write strobe reaching this block has already been synchronised to `clk`, so one clock with `wr_vld` high counts as one bus write. Array timing, erase timers and strobe edge filtering are handled outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, no request is raised, `id_mode` is 0, and `rd_data` equals `arr_rdata`.
- R2: Byte program takes four writes: AA to 555, 55 to 2AA, A0 to 555, then any address with any data. One cycle after the fourth write, `req_prog` is high and `req_addr`/`req_data` carry that write's address and data.
- R3: Command addresses are matched on address bits 10..0 only. Bits 17..11 can take any value, so both AAA and 2AA are accepted for a 55 write.
- R4: Chip erase takes six writes: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555. One cycle after the sixth write, `req_chip_erase` is high.
- R5: Sector erase uses the same first five writes as chip erase, then 30 to any address. One cycle later, `req_sect_erase` is high and `req_addr` holds the address of that final write.
- R6: Boot-lock enable uses the same first five writes, then 40@555. One cycle later, `req_lock` is high.
- R7: AA@555, 55@2AA, 90@555 sets `id_mode` one cycle after the third write. No request is raised.
- R8: A write of F0 to any address clears `id_mode` and returns the sequencer to idle from every state except the one waiting for program data. In that state, F0 is programmed as data. Because of this rule, the unlock pair followed by F0@555 also leaves identification mode.
- R9: In identification mode, `rd_data` is selected by `rd_addr[1:0]`: 0 gives 1F; 1 gives 07 when `TOP_BOOT`=0 or 08 when `TOP_BOOT`=1; 3 gives 0F.
- R10: In identification mode, `rd_addr[1:0]`=2 inside the 16 KiB boot sector returns `{7'b0, boot_locked}`. The same offset outside the boot sector returns 00. With the default `TOP_BOOT`=0, the boot sector is the region where address bits 17..14 are all zero.
- R11: A write that does not match the next expected step sends the sequencer back to idle with no request. That write does not count as the first step of a new sequence.
- R12: While `erase_busy` is high, writes are ignored entirely. No request follows, `id_mode` does not change, and the sequence state does not change.
- R13: Outside identification mode, `rd_data` equals `arr_rdata`.
- R14: At most one request is high in any cycle, and each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_vld | input | 1 | One accepted bus write this cycle |
| wr_addr | input | 18 | Full byte address of the write |
| wr_data | input | 8 | Write data |
| erase_busy | input | 1 | Chip erase in progress; writes are ignored |
| rd_addr | input | 18 | Read address |
| arr_rdata | input | 8 | Data from the array or status path |
| boot_locked | input | 1 | Current boot-sector lock state |
| req_prog | output | 1 | Byte program request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sect_erase | output | 1 | Sector erase request pulse |
| req_lock | output | 1 | Boot-lock enable request pulse |
| req_addr | output | 18 | Address of the final write of the last request |
| req_data | output | 8 | Data of the final write of the last request |
| id_mode | output | 1 | Identification mode active |
| rd_data | output | 8 | Read data returned to the host |

## Verification
Request pulses and the `id_mode` flag are registered. Each one is due in the cycle after the clock edge that accepted the final write, and it is gone one cycle after that. `rd_data` is combinational from `rd_addr`, `id_mode`, `arr_rdata` and `boot_locked`, so it is valid in the same cycle. The bench drives each write at a falling edge, releases it at the next falling edge, and reads the request flags at that moment, which is exactly one register stage after acceptance. It then checks again one cycle later to confirm each pulse ends. Read checks set `rd_addr` and sample a nanosecond later, away from any rising edge.

// File: rtl/fcs_pkg.sv
// Package: shared state encoding and command byte values for the flash
// command sequencer. Assumes byte-wide command data.
package fcs_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS1, S_ERS2, S_ERS3
    } seq_state_t;

    localparam logic [7:0] CD_KEY_A  = 8'hAA;
    localparam logic [7:0] CD_KEY_B  = 8'h55;
    localparam logic [7:0] CD_PROG   = 8'hA0;
    localparam logic [7:0] CD_ERASE  = 8'h80;
    localparam logic [7:0] CD_CHIP   = 8'h10;
    localparam logic [7:0] CD_SECT   = 8'h30;
    localparam logic [7:0] CD_LOCK   = 8'h40;
    localparam logic [7:0] CD_ID_IN  = 8'h90;
    localparam logic [7:0] CD_ID_OUT = 8'hF0;

    localparam logic [7:0] ID_MAKER  = 8'h1F;
    localparam logic [7:0] ID_DEV_LO = 8'h07;
    localparam logic [7:0] ID_DEV_HI = 8'h08;
    localparam logic [7:0] ID_EXTRA  = 8'h0F;
endpackage

// File: rtl/fcs_addr_match.sv
// Address matcher: flags the two command addresses, comparing only the
// low CMP_W bits of the bus address. Assumes CMP_W <= ADDR_W.
module fcs_addr_match #(
    parameter int ADDR_W = 18,
    parameter int CMP_W  = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_first,
    output logic              hit_second
);
    localparam logic [CMP_W-1:0] KEY_FIRST  = CMP_W'(12'h555);
    localparam logic [CMP_W-1:0] KEY_SECOND = CMP_W'(12'h2AA);

    // Compare the decoded low bits against both command addresses.
    always_comb begin
        hit_first  = (addr[CMP_W-1:0] == KEY_FIRST);
        hit_second = (addr[CMP_W-1:0] == KEY_SECOND);
    end
endmodule

// File: rtl/fcs_seq_fsm.sv
// Sequence engine: steps through unlock and command writes and raises
// one-cycle registered requests. Assumes wr_go is already qualified by
// the busy input and lasts one cycle per bus write.
module fcs_seq_fsm
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              hit_first,
    input  logic              hit_second,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sect_erase,
    output logic              req_lock,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data,
    output logic              id_mode
);
    seq_state_t state, nxt;
    logic n_prog, n_chip, n_sect, n_lock, n_id, n_any;

    // Next-state and request decode for one accepted write.
    always_comb begin
        nxt    = state;
        n_prog = 1'b0;
        n_chip = 1'b0;
        n_sect = 1'b0;
        n_lock = 1'b0;
        n_id   = id_mode;
        if (wr_go) begin
            nxt = S_IDLE;
            if (state != S_PROG && wr_data == CD_ID_OUT) begin
                n_id = 1'b0;
            end else begin
                case (state)
                    S_IDLE: if (hit_first && wr_data == CD_KEY_A)  nxt = S_UNL1;
                    S_UNL1: if (hit_second && wr_data == CD_KEY_B) nxt = S_UNL2;
                    S_UNL2: if (hit_first) begin
                        case (wr_data)
                            CD_PROG:  nxt  = S_PROG;
                            CD_ERASE: nxt  = S_ERS1;
                            CD_ID_IN: n_id = 1'b1;
                            default:  nxt  = S_IDLE;
                        endcase
                    end
                    S_PROG: n_prog = 1'b1;
                    S_ERS1: if (hit_first && wr_data == CD_KEY_A)  nxt = S_ERS2;
                    S_ERS2: if (hit_second && wr_data == CD_KEY_B) nxt = S_ERS3;
                    S_ERS3: begin
                        if (wr_data == CD_SECT)                   n_sect = 1'b1;
                        else if (hit_first && wr_data == CD_CHIP) n_chip = 1'b1;
                        else if (hit_first && wr_data == CD_LOCK) n_lock = 1'b1;
                    end
                    default: nxt = S_IDLE;
                endcase
            end
        end
        n_any = n_prog | n_chip | n_sect | n_lock;
    end

    // State, mode flag and request pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= S_IDLE;
            id_mode        <= 1'b0;
            req_prog       <= 1'b0;
            req_chip_erase <= 1'b0;
            req_sect_erase <= 1'b0;
            req_lock       <= 1'b0;
        end else begin
            state          <= nxt;
            id_mode        <= n_id;
            req_prog       <= n_prog;
            req_chip_erase <= n_chip;
            req_sect_erase <= n_sect;
            req_lock       <= n_lock;
        end
    end

    // Capture the final write's address and data alongside a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_data <= '0;
        end else if (n_any) begin
            req_addr <= wr_addr;
            req_data <= wr_data;
        end
    end
endmodule

// File: rtl/fcs_id_read.sv
// Read mux: returns identification bytes in ID mode, otherwise passes
// array data through. TOP_BOOT selects boot-sector placement and the
// device code. Assumes ADDR_W > BOOT_W.
module fcs_id_read
    import fcs_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int BOOT_W   = 14,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    input  logic              boot_locked,
    output logic [7:0]        rd_data
);
    localparam int HI_W = ADDR_W - BOOT_W;
    logic       in_boot;
    logic [7:0] dev_code;

    generate
        if (TOP_BOOT) begin : g_top
            assign in_boot  = &rd_addr[ADDR_W-1:BOOT_W];
            assign dev_code = ID_DEV_HI;
        end else begin : g_bottom
            assign in_boot  = (rd_addr[ADDR_W-1:BOOT_W] == HI_W'(0));
            assign dev_code = ID_DEV_LO;
        end
    endgenerate

    // Choose between the identification table and the array path.
    always_comb begin
        if (!id_mode) begin
            rd_data = arr_rdata;
        end else begin
            case (rd_addr[1:0])
                2'd0:    rd_data = ID_MAKER;
                2'd1:    rd_data = dev_code;
                2'd2:    rd_data = in_boot ? {7'b0, boot_locked} : 8'h00;
                default: rd_data = ID_EXTRA;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Top: flash command sequencer. Decodes unlock and command write
// sequences into one-cycle requests and serves identification reads.
// Assumes wr_vld is synchronous and one cycle per bus write.
module flash_cmd_seq #(
    parameter int ADDR_W   = 18,
    parameter int CMP_W    = 11,
    parameter int BOOT_W   = 14,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    input  logic              boot_locked,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sect_erase,
    output logic              req_lock,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data,
    output logic              id_mode,
    output logic [7:0]        rd_data
);
    logic wr_go, hit_first, hit_second;

    // Drop writes while a chip erase is running.
    always_comb wr_go = wr_vld & ~erase_busy;

    fcs_addr_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
        .addr      (wr_addr),
        .hit_first (hit_first),
        .hit_second(hit_second)
    );

    fcs_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_go         (wr_go),
        .hit_first     (hit_first),
        .hit_second    (hit_second),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .req_prog      (req_prog),
        .req_chip_erase(req_chip_erase),
        .req_sect_erase(req_sect_erase),
        .req_lock      (req_lock),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .id_mode       (id_mode)
    );

    fcs_id_read #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .TOP_BOOT(TOP_BOOT)) u_rd (
        .id_mode    (id_mode),
        .rd_addr    (rd_addr),
        .arr_rdata  (arr_rdata),
        .boot_locked(boot_locked),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/fcs_chk.sv
// Checker: temporal properties of the sequencer's ports, bound to the top.
module fcs_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_vld,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              erase_busy,
    input logic [7:0]        arr_rdata,
    input logic              req_prog,
    input logic              req_chip_erase,
    input logic              req_sect_erase,
    input logic              req_lock,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_data,
    input logic              id_mode,
    input logic [7:0]        rd_data
);
    logic [3:0] reqs;
    assign reqs = {req_prog, req_chip_erase, req_sect_erase, req_lock};

    // R14
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));
    // R14
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|reqs) |=> !(|reqs));
    // R12
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> (!(|reqs) && $stable(id_mode)));
    // R2
    prog_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_prog |-> ($past(wr_vld) && req_addr == $past(wr_addr)
                      && req_data == $past(wr_data)));
    // R4
    chip_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_chip_erase |-> ($past(wr_data) == 8'h10
                            && $past(wr_addr[10:0]) == 11'h555));
    // R7
    id_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> ($past(wr_vld) && $past(wr_data) == 8'h90));
    // R13
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> (rd_data == arr_rdata));
endmodule

bind flash_cmd_seq fcs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_vld        (wr_vld),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .erase_busy    (erase_busy),
    .arr_rdata     (arr_rdata),
    .req_prog      (req_prog),
    .req_chip_erase(req_chip_erase),
    .req_sect_erase(req_sect_erase),
    .req_lock      (req_lock),
    .req_addr      (req_addr),
    .req_data      (req_data),
    .id_mode       (id_mode),
    .rd_data       (rd_data)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_vld = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        erase_busy = 1'b0;
    logic [17:0] rd_addr = '0;
    logic [7:0]  arr_rdata = 8'h5A;
    logic        boot_locked = 1'b0;
    logic        req_prog, req_chip_erase, req_sect_erase, req_lock, id_mode;
    logic [17:0] req_addr;
    logic [7:0]  req_data, rd_data;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;
    bit  exp_id = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] reqv();
        return {req_prog, req_chip_erase, req_sect_erase, req_lock};
    endfunction

    function automatic logic [17:0] rnd_hi(input logic [10:0] lo);
        logic [17:0] r = 18'($urandom);
        return {r[17:11], lo};
    endfunction

    // Expected identification read value (R9, R10), default bottom boot.
    function automatic logic [7:0] id_exp(input logic [17:0] a, input logic lk);
        case (a[1:0])
            2'd0: return 8'h1F;
            2'd1: return 8'h07;
            2'd2: return (a[17:14] == 4'd0) ? {7'b0, lk} : 8'h00;
            default: return 8'h0F;
        endcase
    endfunction

    // Expected request vector per command kind: {prog, chip, sect, lock}.
    function automatic logic [3:0] req_exp(input int kind);
        case (kind)
            0: return 4'b1000;
            1: return 4'b0100;
            2: return 4'b0010;
            3: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    // One bus write; returns at the falling edge after acceptance.
    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_vld = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic wr_quiet(input logic [17:0] a, input logic [7:0] d, input string tag);
        wr(a, d);
        check(tag, reqv(), 4'b0000);
    endtask

    task automatic unlock(input string tag);
        wr_quiet(rnd_hi(11'h555), 8'hAA, tag);
        wr_quiet(rnd_hi(11'h2AA), 8'h55, tag);
    endtask

    // kinds: 0 prog, 1 chip, 2 sect, 3 lock, 4 id in, 5 id out long, 6 id out short
    task automatic run_cmd(input int kind, input logic [17:0] ta, input logic [7:0] td,
                           input string tag);
        logic [17:0] fa;
        logic [7:0]  fd;
        fa = rnd_hi(11'h555);
        if (kind != 6) unlock(tag);
        case (kind)
            0: begin wr_quiet(rnd_hi(11'h555), 8'hA0, tag); fa = ta; fd = td; end
            1: fd = 8'h10;
            2: begin fa = ta; fd = 8'h30; end
            3: fd = 8'h40;
            4: fd = 8'h90;
            5: fd = 8'hF0;
            default: begin fa = ta; fd = 8'hF0; end
        endcase
        if (kind >= 1 && kind <= 3) begin
            wr_quiet(rnd_hi(11'h555), 8'h80, tag);
            unlock(tag);
        end
        wr(fa, fd);
        check(tag, reqv(), req_exp(kind));
        if (kind == 0 || kind == 2) check(tag, req_addr, fa);
        if (kind == 0) check(tag, req_data, fd);
        if (kind == 4) exp_id = 1;
        if (kind >= 5) exp_id = 0;
        @(negedge clk);
        check({tag, " R14 pulse ends"}, reqv(), 4'b0000);
        check({tag, " id_mode"}, id_mode, exp_id);
    endtask

    task automatic rd_chk(input logic [17:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic finish_up();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reqs in reset", reqv(), 4'b0000);
        check("R1 id in reset", id_mode, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reqs after reset", reqv(), 4'b0000);
        check("R1 id after reset", id_mode, 1'b0);
        rd_chk(18'h00001, 8'h5A, "R1 read pass-through");

        // R2 / R3: program with both alias addresses and upper bits set
        wr_quiet(18'h00555, 8'hAA, "R2 step1");
        wr_quiet(18'h00AAA, 8'h55, "R3 alias AAA");
        wr_quiet(18'h3F555, 8'hA0, "R3 upper bits ignored");
        wr(18'h12345, 8'h3C);
        check("R2 prog req", reqv(), 4'b1000);
        check("R2 prog addr", req_addr, 18'h12345);
        check("R2 prog data", req_data, 8'h3C);
        wr_quiet(18'h00555, 8'hAA, "R3 step1");
        wr_quiet(18'h002AA, 8'h55, "R3 alias 2AA");
        wr_quiet(18'h00555, 8'hA0, "R3 step3");
        // R8: F0 as program data is programmed, not a reset
        wr(18'h0BEEF, 8'hF0);
        check("R8 F0 as prog data", reqv(), 4'b1000);
        check("R8 F0 data", req_data, 8'hF0);

        run_cmd(1, 18'h0, 8'h0, "R4 chip erase");
        run_cmd(2, 18'h2C123, 8'h0, "R5 sector erase");
        run_cmd(3, 18'h0, 8'h0, "R6 lock enable");
        run_cmd(4, 18'h0, 8'h0, "R7 id entry");

        // R9 / R10: identification reads
        rd_chk(18'h00000, 8'h1F, "R9 maker");
        rd_chk(18'h00001, 8'h07, "R9 device");
        rd_chk(18'h00003, 8'h0F, "R9 extra");
        boot_locked = 1'b0;
        rd_chk(18'h00002, 8'h00, "R10 unlocked");
        boot_locked = 1'b1;
        rd_chk(18'h00002, 8'h01, "R10 locked");
        rd_chk(18'h3C002, 8'h00, "R10 outside boot");

        // R12: busy drops writes, including F0
        erase_busy = 1'b1;
        wr_quiet(18'h00000, 8'hF0, "R12 F0 while busy");
        check("R12 id kept", id_mode, 1'b1);
        wr_quiet(18'h00555, 8'hAA, "R12 busy step1");
        wr_quiet(18'h002AA, 8'h55, "R12 busy step2");
        wr_quiet(18'h00555, 8'hA0, "R12 busy step3");
        wr_quiet(18'h01000, 8'h11, "R12 busy step4");
        erase_busy = 1'b0;
        wr_quiet(18'h01000, 8'h11, "R12 no sequence resumed");

        run_cmd(6, 18'h2ABCD, 8'h0, "R8 short exit");
        rd_chk(18'h00000, 8'h5A, "R13 pass after exit");
        run_cmd(4, 18'h0, 8'h0, "R7 re-entry");
        run_cmd(5, 18'h0, 8'h0, "R8 long exit");

        // R11: broken sequences
        wr_quiet(18'h00555, 8'hAA, "R11 step1");
        wr_quiet(18'h00123, 8'h55, "R11 bad address");
        wr_quiet(18'h00555, 8'hA0, "R11 no unlock");
        wr_quiet(18'h00400, 8'h77, "R11 no program");
        unlock("R11 erase prefix");
        wr_quiet(18'h00555, 8'h80, "R11 erase step3");
        wr_quiet(18'h00554, 8'hAA, "R11 bad second unlock");
        wr_quiet(18'h00555, 8'h10, "R11 no chip erase");
        run_cmd(1, 18'h0, 8'h0, "R11 recovery");

        // Random commands and reads
        for (int i = 0; i < 300; i++) begin
            int          k;
            logic [17:0] ra;
            k = int'($urandom % 7);
            run_cmd(k, 18'($urandom), 8'($urandom), "R2 R5 random cmd");
            arr_rdata = 8'($urandom);
            boot_locked = 1'($urandom);
            ra = 18'($urandom);
            if ($urandom % 2 == 1) ra[17:14] = 4'd0;
            rd_chk(ra, exp_id ? id_exp(ra, boot_locked) : arr_rdata, "R9 R13 random read");
        end
        finish_up();
    end
endmodule